// File: doc/BRIEF.md
# Committed Store Drain Queue

This block keeps every store from the moment it is dispatched until its data has gone to the data cache. Each slot holds a sequence number, an address, a byte size, the data, a store-conditional marker and three progress bits: eligible to drain, handed to the cache, and done. The slot index is the store's tag. It is returned at dispatch and used later by execute and by the cache's completion return.

Stores become eligible in two ways. A commit number covers all stores at or below it. A store-conditional becomes eligible as soon as it executes. Every cycle a combinational scan starts at the oldest slot and offers eligible stores to the cache on up to `PORTS` request lanes. The scan retires zero-size stores and failing store-conditionals on the spot, with no request. A rejected lane freezes the drain until the cache signals a retry. A squash trims speculative stores from the young end.

A single load may be parked on one store. When that store leaves the queue, the block raises a one-cycle replay request carrying the load's identifier.

Top module: `store_wb_queue`

## Requirements
- R1: After synchronous reset no request lane is valid, the pending-drain count is 0, the allocation tag is 0 and the queue does not report full.
- R2: Dispatch takes the slot named by `alloc_tag`, and tags advance by one modulo `DEPTH`. With `DEPTH` stores held, `sq_full` is 1 and a dispatch has no effect, so the tag stays the same.
- R3: A commit marks as eligible every held store whose sequence number is less than or equal to the commit number. `wb_pending` rises by one for each store newly marked.
- R4: The drain scan offers eligible stores oldest first on lanes filled from lane 0 upward, at most `PORTS` per cycle. It offers nothing at or beyond the first held store that is not yet eligible.
- R5: An eligible store of size 0 is retired at the next edge without any request, and `wb_pending` drops by one.
- R6: Stores already accepted by the cache, and stores executed with the prefetch marker, are skipped by the scan. A prefetch store is retired only by the completion return.
- R7: A store-conditional becomes eligible when it executes, without a commit. When the scan reaches it, `sc_valid` pulses with its tag and with `sc_code`: 2 if it was executed as uncacheable, otherwise 1 if `lock_flag` is high, otherwise 0. Codes 2 and 1 issue a request; code 0 retires it without one.
- R8: If a valid lane is not accepted, the queue becomes blocked. Lanes above the first rejected lane are withdrawn and are not counted as sent. While blocked, no lane is valid.
- R9: A `req_retry` pulse clears the blocked state in the same cycle, and the held store is offered again on lane 0 ahead of any younger store.
- R10: A completion return for a held tag frees that slot and lowers `wb_pending` by one.
- R11: A store leaving the queue whose sequence number matches the parked store raises `replay_valid` for one cycle, at the next edge, with the parked load's identifier, and the parking is cleared.
- R12: A squash removes, starting at the youngest, each store with a sequence number greater than the squash number. It stops at the first store already eligible, and `alloc_tag` moves back by the number removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch a new store |
| disp_seq | input | SEQ_W | Sequence number of the dispatched store |
| disp_sc | input | 1 | Dispatched store is a store-conditional |
| alloc_tag | output | IDX_W | Tag the next dispatch will take |
| sq_full | output | 1 | All slots are held |
| exe_valid | input | 1 | Execute result for a held store |
| exe_tag | input | IDX_W | Tag being executed |
| exe_addr | input | ADDR_W | Store address |
| exe_size | input | SIZE_W | Store size in bytes, 0 allowed |
| exe_data | input | DATA_W | Store data |
| exe_uncached | input | 1 | Address is uncacheable |
| exe_prefetch | input | 1 | Store is a data prefetch |
| cmt_valid | input | 1 | Commit number is valid |
| cmt_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Stores above this number are removed |
| req_valid | output | PORTS | Per-lane cache request valid |
| req_tag | output | PORTS*IDX_W | Per-lane store tag |
| req_addr | output | PORTS*ADDR_W | Per-lane address |
| req_size | output | PORTS*SIZE_W | Per-lane size |
| req_data | output | PORTS*DATA_W | Per-lane data |
| req_accept | input | PORTS | Per-lane acceptance by the cache |
| req_retry | input | 1 | Cache can take the held request again |
| cpl_valid | input | 1 | Completion return |
| cpl_tag | input | IDX_W | Tag of the completed store |
| lock_flag | input | 1 | Reservation for store-conditionals is held |
| sc_valid | output | 1 | Store-conditional result valid |
| sc_tag | output | IDX_W | Tag of that store-conditional |
| sc_code | output | 2 | 0 fail, 1 success, 2 uncacheable |
| stall_set | input | 1 | Park a load on a store |
| stall_seq | input | SEQ_W | Sequence number of the store the load waits for |
| stall_load | input | LOAD_W | Identifier of the parked load |
| replay_valid | output | 1 | Replay the parked load |
| replay_load | output | LOAD_W | Identifier of the load to replay |
| wb_pending | output | IDX_W+1 | Stores eligible and not yet retired |

## Verification
The bench rejects lane 0 while lane 1 is accepted. A queue that marked the withdrawn lane as sent would never offer that store again, and one that ignored the rejection would keep issuing while blocked. It offers more eligible stores than there are lanes, where a design without a budget would overrun the lanes. It squashes behind an eligible store, where a design that did not stop there would drop a committed store and pull `alloc_tag` back too far. It covers all three store-conditional codes and the zero-size and prefetch paths, where a design that issued a request for code 0 or size 0, or drained a prefetch, would show a spurious lane. It fills the queue to capacity, where a design that accepted a dispatch while full would move `alloc_tag`.

// File: rtl/sqwb_pkg.sv
package sqwb_pkg;
  typedef enum logic [1:0] {
    SC_FAIL     = 2'd0,
    SC_OK       = 2'd1,
    SC_UNCACHED = 2'd2
  } sc_code_e;
endpackage

// File: rtl/sqwb_scan.sv
// Oldest-first drain scan: fills request lanes, retires zero-size stores
// and failing store-conditionals, and stops at the first ineligible store.
module sqwb_scan
  import sqwb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int SIZE_W = 4,
  parameter int PORTS  = 2
) (
  input  logic [IDX_W-1:0]        head_idx,
  input  logic [IDX_W:0]          occ,
  input  logic                    halt,
  input  logic                    lock,
  input  logic [DEPTH-1:0]        vld,
  input  logic [DEPTH-1:0]        elig,
  input  logic [DEPTH-1:0]        sent,
  input  logic [DEPTH-1:0]        is_sc,
  input  logic [DEPTH-1:0]        pf,
  input  logic [DEPTH-1:0]        unc,
  input  logic [DEPTH*SIZE_W-1:0] sizes,
  output logic [PORTS-1:0]        lane_v,
  output logic [PORTS*IDX_W-1:0]  lane_idx,
  output logic [DEPTH-1:0]        zero_done,
  output logic [DEPTH-1:0]        sc_done,
  output logic                    sc_v,
  output logic [IDX_W-1:0]        sc_idx,
  output sc_code_e                sc_code
);
  always_comb begin
    int              used;
    logic            stop;
    logic [IDX_W-1:0] idx;
    used      = 0;
    stop      = halt;
    idx       = '0;
    lane_v    = '0;
    lane_idx  = '0;
    zero_done = '0;
    sc_done   = '0;
    sc_v      = 1'b0;
    sc_idx    = '0;
    sc_code   = SC_FAIL;
    for (int o = 0; o < DEPTH; o++) begin
      idx = head_idx + IDX_W'(o);
      if (!stop && ((IDX_W+1)'(o) < occ) && vld[idx]) begin
        if (!elig[idx]) begin
          stop = 1'b1;
        end else if (sent[idx] || pf[idx]) begin
          stop = stop;
        end else if (sizes[idx*SIZE_W +: SIZE_W] == '0) begin
          zero_done[idx] = 1'b1;
        end else if (is_sc[idx]) begin
          sc_v   = 1'b1;
          sc_idx = idx;
          stop   = 1'b1;
          if (unc[idx])  sc_code = SC_UNCACHED;
          else if (lock) sc_code = SC_OK;
          else           sc_code = SC_FAIL;
          if (sc_code == SC_FAIL) begin
            sc_done[idx] = 1'b1;
          end else begin
            lane_v[used] = 1'b1;
            lane_idx[used*IDX_W +: IDX_W] = idx;
            used++;
          end
        end else begin
          lane_v[used] = 1'b1;
          lane_idx[used*IDX_W +: IDX_W] = idx;
          used++;
          if (used == PORTS) stop = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sqwb_squash.sv
// Young-end trim: counts consecutive removable stores from the tail.
module sqwb_squash #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int SEQ_W = 16
) (
  input  logic                   sq_valid,
  input  logic [SEQ_W-1:0]       sq_seq,
  input  logic [IDX_W-1:0]       tail_idx,
  input  logic [IDX_W:0]         occ,
  input  logic [DEPTH-1:0]       vld,
  input  logic [DEPTH-1:0]       elig,
  input  logic [DEPTH*SEQ_W-1:0] seqs,
  output logic [DEPTH-1:0]       kill,
  output logic [IDX_W:0]         kill_n
);
  always_comb begin
    logic             go;
    logic [IDX_W-1:0] idx;
    go     = sq_valid;
    idx    = '0;
    kill   = '0;
    kill_n = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = tail_idx - IDX_W'(k + 1);
      if (go && ((IDX_W+1)'(k) < occ) && vld[idx] && !elig[idx] &&
          (seqs[idx*SEQ_W +: SEQ_W] > sq_seq)) begin
        kill[idx] = 1'b1;
        kill_n    = kill_n + 1'b1;
      end else begin
        go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/sqwb_lanes.sv
// Resolves per-lane acceptance in lane order; first rejection withdraws the rest.
module sqwb_lanes #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int PORTS = 2
) (
  input  logic [PORTS-1:0]       lane_v,
  input  logic [PORTS*IDX_W-1:0] lane_idx,
  input  logic [PORTS-1:0]       accept,
  output logic [DEPTH-1:0]       sent_mask,
  output logic                   reject
);
  always_comb begin
    logic ok;
    ok        = 1'b1;
    sent_mask = '0;
    reject    = 1'b0;
    for (int k = 0; k < PORTS; k++) begin
      if (lane_v[k] && ok) begin
        if (accept[k]) begin
          sent_mask[lane_idx[k*IDX_W +: IDX_W]] = 1'b1;
        end else begin
          reject = 1'b1;
          ok     = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/store_wb_queue.sv
// Store queue top: slot state, commit marking, drain, squash and load replay.
module store_wb_queue
  import sqwb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4,
  parameter int PORTS  = 2,
  parameter int LOAD_W = 6,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    disp_valid,
  input  logic [SEQ_W-1:0]        disp_seq,
  input  logic                    disp_sc,
  output logic [IDX_W-1:0]        alloc_tag,
  output logic                    sq_full,
  input  logic                    exe_valid,
  input  logic [IDX_W-1:0]        exe_tag,
  input  logic [ADDR_W-1:0]       exe_addr,
  input  logic [SIZE_W-1:0]       exe_size,
  input  logic [DATA_W-1:0]       exe_data,
  input  logic                    exe_uncached,
  input  logic                    exe_prefetch,
  input  logic                    cmt_valid,
  input  logic [SEQ_W-1:0]        cmt_seq,
  input  logic                    squash_valid,
  input  logic [SEQ_W-1:0]        squash_seq,
  output logic [PORTS-1:0]        req_valid,
  output logic [PORTS*IDX_W-1:0]  req_tag,
  output logic [PORTS*ADDR_W-1:0] req_addr,
  output logic [PORTS*SIZE_W-1:0] req_size,
  output logic [PORTS*DATA_W-1:0] req_data,
  input  logic [PORTS-1:0]        req_accept,
  input  logic                    req_retry,
  input  logic                    cpl_valid,
  input  logic [IDX_W-1:0]        cpl_tag,
  input  logic                    lock_flag,
  output logic                    sc_valid,
  output logic [IDX_W-1:0]        sc_tag,
  output logic [1:0]              sc_code,
  input  logic                    stall_set,
  input  logic [SEQ_W-1:0]        stall_seq,
  input  logic [LOAD_W-1:0]       stall_load,
  output logic                    replay_valid,
  output logic [LOAD_W-1:0]       replay_load,
  output logic [IDX_W:0]          wb_pending
);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0]  head_q, tail_q;
  logic [DEPTH-1:0]  vld_q, elig_q, sent_q, sc_q, pf_q, unc_q;
  logic [SEQ_W-1:0]  seq_q  [DEPTH];
  logic [SIZE_W-1:0] size_q [DEPTH];
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic              blocked_q;
  logic              stall_v_q;
  logic [SEQ_W-1:0]  stall_seq_q;
  logic [LOAD_W-1:0] stall_load_q;
  logic [IDX_W:0]    pend_q;

  logic [PTR_W-1:0]          occ;
  logic [IDX_W-1:0]          head_idx, tail_idx;
  logic                      halt, disp_ok;
  logic [DEPTH*SIZE_W-1:0]   sizes_flat;
  logic [DEPTH*SEQ_W-1:0]    seqs_flat;
  logic [PORTS-1:0]          lane_v;
  logic [PORTS*IDX_W-1:0]    lane_idx;
  logic [DEPTH-1:0]          zero_done, sc_done, sent_mask, kill, set_wb, cpl_mask, free_mask;
  logic [IDX_W:0]            kill_n;
  logic                      reject, sc_v, replay_hit;
  logic [IDX_W-1:0]          sc_idx;
  sc_code_e                  sc_c;

  assign occ      = tail_q - head_q;
  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign sq_full  = (occ == PTR_W'(DEPTH));
  assign halt     = blocked_q && !req_retry;
  assign disp_ok  = disp_valid && !sq_full && !squash_valid;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_flat
      assign sizes_flat[i*SIZE_W +: SIZE_W] = size_q[i];
      assign seqs_flat[i*SEQ_W +: SEQ_W]    = seq_q[i];
    end
  endgenerate

  sqwb_scan #(.DEPTH(DEPTH), .IDX_W(IDX_W), .SIZE_W(SIZE_W), .PORTS(PORTS)) u_scan (
    .head_idx(head_idx), .occ(occ), .halt(halt), .lock(lock_flag),
    .vld(vld_q), .elig(elig_q), .sent(sent_q), .is_sc(sc_q), .pf(pf_q), .unc(unc_q),
    .sizes(sizes_flat), .lane_v(lane_v), .lane_idx(lane_idx),
    .zero_done(zero_done), .sc_done(sc_done),
    .sc_v(sc_v), .sc_idx(sc_idx), .sc_code(sc_c)
  );

  sqwb_squash #(.DEPTH(DEPTH), .IDX_W(IDX_W), .SEQ_W(SEQ_W)) u_squash (
    .sq_valid(squash_valid), .sq_seq(squash_seq), .tail_idx(tail_idx), .occ(occ),
    .vld(vld_q), .elig(elig_q), .seqs(seqs_flat), .kill(kill), .kill_n(kill_n)
  );

  sqwb_lanes #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PORTS(PORTS)) u_lanes (
    .lane_v(lane_v), .lane_idx(lane_idx), .accept(req_accept),
    .sent_mask(sent_mask), .reject(reject)
  );

  function automatic logic [IDX_W:0] popc(input logic [DEPTH-1:0] v);
    logic [IDX_W:0] n;
    n = '0;
    for (int i = 0; i < DEPTH; i++) n = n + {{IDX_W{1'b0}}, v[i]};
    return n;
  endfunction

  always_comb begin
    set_wb     = '0;
    replay_hit = 1'b0;
    cpl_mask   = cpl_valid ? (DEPTH'(1) << cpl_tag) : '0;
    free_mask  = (zero_done | sc_done | cpl_mask) & vld_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && !elig_q[i] && !kill[i]) begin
        if (cmt_valid && (seq_q[i] <= cmt_seq)) set_wb[i] = 1'b1;
        if (exe_valid && (exe_tag == IDX_W'(i)) && sc_q[i]) set_wb[i] = 1'b1;
      end
      if (free_mask[i] && stall_v_q && (seq_q[i] == stall_seq_q)) replay_hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q       <= '0;
      tail_q       <= '0;
      vld_q        <= '0;
      elig_q       <= '0;
      sent_q       <= '0;
      sc_q         <= '0;
      pf_q         <= '0;
      unc_q        <= '0;
      blocked_q    <= 1'b0;
      stall_v_q    <= 1'b0;
      stall_seq_q  <= '0;
      stall_load_q <= '0;
      replay_valid <= 1'b0;
      replay_load  <= '0;
      pend_q       <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (disp_ok && (tail_idx == IDX_W'(i))) begin
          vld_q[i]  <= 1'b1;
          elig_q[i] <= 1'b0;
          sent_q[i] <= 1'b0;
          sc_q[i]   <= disp_sc;
          pf_q[i]   <= 1'b0;
          unc_q[i]  <= 1'b0;
          seq_q[i]  <= disp_seq;
          size_q[i] <= '0;
        end else begin
          if (free_mask[i] || kill[i]) vld_q[i] <= 1'b0;
          if (set_wb[i])    elig_q[i] <= 1'b1;
          if (sent_mask[i]) sent_q[i] <= 1'b1;
          if (exe_valid && (exe_tag == IDX_W'(i)) && vld_q[i]) begin
            pf_q[i]   <= exe_prefetch;
            unc_q[i]  <= exe_uncached;
            size_q[i] <= exe_size;
          end
        end
      end
      if (squash_valid)  tail_q <= tail_q - kill_n;
      else if (disp_ok)  tail_q <= tail_q + 1'b1;
      if ((occ != '0) && !vld_q[head_idx]) head_q <= head_q + 1'b1;
      if (reject)         blocked_q <= 1'b1;
      else if (req_retry) blocked_q <= 1'b0;
      pend_q <= pend_q + popc(set_wb) - popc(free_mask & elig_q);
      replay_valid <= replay_hit;
      if (replay_hit) replay_load <= stall_load_q;
      if (stall_set) begin
        stall_v_q    <= 1'b1;
        stall_seq_q  <= stall_seq;
        stall_load_q <= stall_load;
      end else if (replay_hit) begin
        stall_v_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (exe_valid) begin
      addr_mem[exe_tag] <= exe_addr;
      data_mem[exe_tag] <= exe_data;
    end
  end

  generate
    for (genvar k = 0; k < PORTS; k++) begin : g_lane
      logic [IDX_W-1:0] li;
      assign li = lane_idx[k*IDX_W +: IDX_W];
      assign req_tag[k*IDX_W +: IDX_W]    = li;
      assign req_addr[k*ADDR_W +: ADDR_W] = addr_mem[li];
      assign req_data[k*DATA_W +: DATA_W] = data_mem[li];
      assign req_size[k*SIZE_W +: SIZE_W] = size_q[li];
    end
  endgenerate

  assign req_valid  = lane_v;
  assign alloc_tag  = tail_idx;
  assign sc_valid   = sc_v;
  assign sc_tag     = sc_idx;
  assign sc_code    = sc_c;
  assign wb_pending = pend_q;
endmodule

// File: rtl/sqwb_checker.sv
module sqwb_checker #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int PORTS = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [PORTS-1:0] req_valid,
  input logic [PORTS-1:0] req_accept,
  input logic             req_retry,
  input logic             blocked,
  input logic [IDX_W:0]   wb_pending,
  input logic             sq_full,
  input logic             disp_valid,
  input logic             squash_valid,
  input logic [IDX_W-1:0] alloc_tag,
  input logic             sc_valid,
  input logic [1:0]       sc_code
);
  AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (blocked && !req_retry) |-> (req_valid == '0)); // R8
  AST_REJECT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    ((req_valid & ~req_accept) != '0) |=> blocked); // R8
  AST_LANES_PACKED: assert property (@(posedge clk) disable iff (rst)
    ((req_valid & (req_valid + 1'b1)) == '0)); // R4
  AST_PENDING_BOUND: assert property (@(posedge clk) disable iff (rst)
    (wb_pending <= (IDX_W+1)'(DEPTH))); // R3
  AST_FULL_HOLDS_TAG: assert property (@(posedge clk) disable iff (rst)
    (sq_full && disp_valid && !squash_valid) |=> (alloc_tag == $past(alloc_tag))); // R2
  AST_SC_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    sc_valid |-> (sc_code != 2'd3)); // R7
endmodule

bind store_wb_queue sqwb_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PORTS(PORTS)) u_sqwb_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_accept(req_accept),
  .req_retry(req_retry), .blocked(blocked_q), .wb_pending(wb_pending),
  .sq_full(sq_full), .disp_valid(disp_valid), .squash_valid(squash_valid),
  .alloc_tag(alloc_tag), .sc_valid(sc_valid), .sc_code(sc_code)
);

// File: tb/tb_store_wb_queue.sv
module tb_store_wb_queue;
  localparam int DEPTH = 8, SEQ_W = 16, ADDR_W = 32, DATA_W = 64, SIZE_W = 4;
  localparam int PORTS = 2, LOAD_W = 6, IDX_W = 3;
  localparam int VW = ADDR_W + SIZE_W + DATA_W;
  localparam logic [VW-1:0] VEC [4] = '{
    {32'h0000_1040, 4'd8, 64'h1111_2222_3333_4444},
    {32'h0000_2080, 4'd4, 64'h0000_0000_DEAD_BEEF},
    {32'h0000_30C0, 4'd2, 64'h0000_0000_0000_ABCD},
    {32'h0000_4100, 4'd1, 64'h0000_0000_0000_005A}
  };

  logic clk = 0, rst = 1;
  logic disp_valid = 0, disp_sc = 0, exe_valid = 0, exe_uncached = 0, exe_prefetch = 0;
  logic [SEQ_W-1:0] disp_seq = 0, cmt_seq = 0, squash_seq = 0, stall_seq = 0;
  logic [IDX_W-1:0] exe_tag = 0, cpl_tag = 0;
  logic [ADDR_W-1:0] exe_addr = 0;
  logic [SIZE_W-1:0] exe_size = 0;
  logic [DATA_W-1:0] exe_data = 0;
  logic cmt_valid = 0, squash_valid = 0, req_retry = 0, cpl_valid = 0, lock_flag = 0, stall_set = 0;
  logic [PORTS-1:0] req_accept = '1;
  logic [LOAD_W-1:0] stall_load = 0;
  logic [IDX_W-1:0] alloc_tag, sc_tag;
  logic sq_full, sc_valid, replay_valid;
  logic [PORTS-1:0] req_valid;
  logic [PORTS*IDX_W-1:0] req_tag;
  logic [PORTS*ADDR_W-1:0] req_addr;
  logic [PORTS*SIZE_W-1:0] req_size;
  logic [PORTS*DATA_W-1:0] req_data;
  logic [1:0] sc_code;
  logic [LOAD_W-1:0] replay_load;
  logic [IDX_W:0] wb_pending;
  int checks = 0, errs = 0;

  always #5 clk = ~clk;

  store_wb_queue dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go();
    @(posedge clk); #2;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic dispatch(input logic [SEQ_W-1:0] s, input logic sc, output logic [IDX_W-1:0] t);
    disp_valid = 1; disp_seq = s; disp_sc = sc; settle(); t = alloc_tag;
    go(); disp_valid = 0; disp_sc = 0;
  endtask

  task automatic execute(input logic [IDX_W-1:0] t, input logic [ADDR_W-1:0] a,
                         input logic [SIZE_W-1:0] sz, input logic [DATA_W-1:0] d,
                         input logic unc, input logic pf);
    exe_valid = 1; exe_tag = t; exe_addr = a; exe_size = sz; exe_data = d;
    exe_uncached = unc; exe_prefetch = pf;
    go(); exe_valid = 0; exe_uncached = 0; exe_prefetch = 0;
  endtask

  task automatic commit(input logic [SEQ_W-1:0] s);
    cmt_valid = 1; cmt_seq = s; go(); cmt_valid = 0;
  endtask

  task automatic complete(input logic [IDX_W-1:0] t);
    cpl_valid = 1; cpl_tag = t; go(); cpl_valid = 0;
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [IDX_W-1:0] t [4];
    logic [IDX_W-1:0] u, a, b, c, s;
    repeat (3) go();
    rst = 0; settle();
    chk("R1 req_valid", req_valid, 0);
    chk("R1 wb_pending", wb_pending, 0);
    chk("R1 alloc_tag", alloc_tag, 0);
    chk("R1 sq_full", sq_full, 0);

    // table walk: four stores, dispatch and execute
    for (int i = 0; i < 4; i++) begin
      dispatch(SEQ_W'(10 + i), 1'b0, t[i]);
      chk("R2 tag order", t[i], i);
    end
    for (int i = 0; i < 4; i++)
      execute(t[i], VEC[i][VW-1 -: ADDR_W], VEC[i][DATA_W +: SIZE_W], VEC[i][DATA_W-1:0], 0, 0);
    settle();
    chk("R3 no drain before commit", req_valid, 0);
    commit(11); settle();
    chk("R3 pending after commit", wb_pending, 2);
    chk("R4 two lanes", req_valid, 2'b11);
    chk("R4 lane0 tag", req_tag[IDX_W-1:0], t[0]);
    chk("R4 lane1 tag", req_tag[2*IDX_W-1:IDX_W], t[1]);
    chk("R4 lane0 addr", req_addr[ADDR_W-1:0], VEC[0][VW-1 -: ADDR_W]);
    chk("R4 lane1 data", req_data[2*DATA_W-1:DATA_W], VEC[1][DATA_W-1:0]);
    chk("R4 lane1 size", req_size[2*SIZE_W-1:SIZE_W], 4);
    go(); settle();
    chk("R6 sent skipped, R4 stop at ineligible", req_valid, 0);
    complete(t[0]); complete(t[1]); settle();
    chk("R10 pending after completions", wb_pending, 0);

    // rejection and retry
    commit(13); settle();
    chk("R4 next pair lane0", req_tag[IDX_W-1:0], t[2]);
    req_accept = 2'b10; go(); req_accept = '1; settle();
    chk("R8 quiet while blocked", req_valid, 0);
    go(); settle();
    chk("R8 still blocked", req_valid, 0);
    req_retry = 1; settle();
    chk("R9 retry reoffers lanes", req_valid, 2'b11);
    chk("R9 held store on lane0", req_tag[IDX_W-1:0], t[2]);
    chk("R8 withdrawn lane reoffered", req_tag[2*IDX_W-1:IDX_W], t[3]);
    go(); req_retry = 0;
    complete(t[2]); complete(t[3]); settle();
    chk("R10 pending zero", wb_pending, 0);

    // port budget
    for (int i = 0; i < 3; i++) begin
      dispatch(SEQ_W'(20 + i), 1'b0, t[i]);
      execute(t[i], 32'h5000 + 32'(i), 4'd8, 64'(i), 0, 0);
    end
    commit(22); settle();
    chk("R4 budget lanes", req_valid, 2'b11);
    chk("R4 budget lane1", req_tag[2*IDX_W-1:IDX_W], t[1]);
    go(); settle();
    chk("R4 third store next cycle", req_valid, 2'b01);
    chk("R4 third tag", req_tag[IDX_W-1:0], t[2]);
    go();
    for (int i = 0; i < 3; i++) complete(t[i]);

    // zero size
    dispatch(30, 1'b0, u);
    execute(u, 32'h6000, 4'd0, 64'h0, 0, 0);
    commit(30); settle();
    chk("R5 no request for size 0", req_valid, 0);
    chk("R5 pending before retire", wb_pending, 1);
    go(); settle();
    chk("R5 pending after retire", wb_pending, 0);

    // store-conditionals
    lock_flag = 0;
    dispatch(50, 1'b1, u);
    execute(u, 32'h7000, 4'd8, 64'h77, 0, 0); settle();
    chk("R7 sc eligible without commit", wb_pending, 1);
    chk("R7 sc valid", sc_valid, 1);
    chk("R7 sc code fail", sc_code, 0);
    chk("R7 sc tag", sc_tag, u);
    chk("R7 fail issues no request", req_valid, 0);
    go(); settle();
    chk("R7 fail retired", wb_pending, 0);
    lock_flag = 1;
    dispatch(51, 1'b1, u);
    execute(u, 32'h7100, 4'd8, 64'h78, 0, 0); settle();
    chk("R7 sc code ok", sc_code, 1);
    chk("R7 ok issues request", req_valid, 2'b01);
    go(); complete(u);
    dispatch(52, 1'b1, u);
    execute(u, 32'h7200, 4'd8, 64'h79, 1, 0); settle();
    chk("R7 sc code uncached", sc_code, 2);
    chk("R7 uncached issues request", req_valid, 2'b01);
    go(); complete(u); lock_flag = 0;

    // prefetch
    dispatch(60, 1'b0, u);
    execute(u, 32'h8000, 4'd8, 64'h1, 0, 1);
    commit(60); settle();
    chk("R6 prefetch skipped", req_valid, 0);
    chk("R6 prefetch pending", wb_pending, 1);
    complete(u); settle();
    chk("R6 prefetch freed by return", wb_pending, 0);

    // squash
    dispatch(70, 1'b0, a); dispatch(71, 1'b0, b); dispatch(72, 1'b0, c);
    execute(a, 32'h9000, 4'd4, 64'h9, 0, 0);
    commit(70); go();
    squash_valid = 1; squash_seq = 69; go(); squash_valid = 0; settle();
    chk("R12 tail retreats to first removed", alloc_tag, b);
    chk("R12 eligible store kept", wb_pending, 1);
    complete(a);
    dispatch(73, 1'b0, u);
    chk("R12 freed tag reused", u, b);
    execute(u, 32'h9100, 4'd2, 64'h5, 0, 0);

    // replay
    dispatch(80, 1'b0, s);
    execute(s, 32'h9200, 4'd4, 64'h6, 0, 0);
    stall_set = 1; stall_seq = 80; stall_load = 6'd5; go(); stall_set = 0;
    commit(80); go();
    complete(u); settle();
    chk("R11 no replay for other store", replay_valid, 0);
    complete(s); settle();
    chk("R11 replay raised", replay_valid, 1);
    chk("R11 replay load id", replay_load, 5);
    go(); settle();
    chk("R11 replay one cycle", replay_valid, 0);

    // full
    repeat (10) go();
    for (int i = 0; i < DEPTH; i++) dispatch(SEQ_W'(90 + i), 1'b0, u);
    settle();
    chk("R2 full", sq_full, 1);
    a = alloc_tag;
    dispatch(98, 1'b0, u); settle();
    chk("R2 ignored when full", alloc_tag, a);
    squash_valid = 1; squash_seq = 89; go(); squash_valid = 0; settle();
    chk("R12 squash all clears full", sq_full, 0);
    chk("R12 squash all tag", alloc_tag, a);
    chk("R10 final pending", wb_pending, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule